// File: doc/BRIEF.md
# Macro Instruction Sequencer with Delay Slots

This block steps through a short program of 32-bit instruction words for a small command-stream macro engine. It holds the program counter as a byte address, presents it to an instruction memory with combinational read, and decides each cycle whether the word on its instruction input is handed to an external execute unit. The execute unit sees an issue strobe for every non-branch instruction that must run.

Only the control fields are decoded here: the branch opcode, the exit flag, the annul bit, the branch condition, the source-register select and the signed word offset. A taken branch is followed by one delay-slot instruction before the jump lands, unless it is annulled. An exit flag lets one more instruction run before the program stops, except when the exit sits in a delay slot. Illegal flow, either a branch in a delay slot or a fetch beyond the loaded program length, stops the run and raises an error. A start pulse launches a run from address 0 at any time.

Top module: `macro_seq`

## Requirements
- R1: After reset, and until the first start, issue, done and errFlag are low and fetchAddr is 0.
- R2: The cycle after a start pulse the sequencer fetches byte address 0 and then handles one instruction per cycle, advancing fetchAddr by 4; every non-branch instruction handled asserts issue for that cycle.
- R3: A word with bits [31:29] = 3'b111 is a branch. Bit 26 picks the test on srcVal (0: taken when zero, 1: taken when non-zero), bits [25:21] drive srcSel, bits [15:0] hold a signed word offset. A branch never asserts issue; a branch not taken continues at the next address.
- R4: A taken branch with the annul bit (bit 27) clear issues the next instruction as its delay slot, then continues at the branch address plus four times the sign-extended offset.
- R5: A taken branch with the annul bit set continues at the target directly; the following word is not issued.
- R6: A word with the exit flag (bit 28), handled outside a delay slot, lets exactly one further instruction issue; then the run halts. An exit flag on a taken branch is ignored.
- R7: The exit flag has no effect on an instruction executing in a delay slot, whether the slot follows a branch or an exit.
- R8: A branch found in a delay slot is not evaluated: the run halts with errFlag set and nothing issued in that cycle.
- R9: When the word index (fetchAddr / 4) is not below progLen, the run halts with errFlag set and nothing issued.
- R10: done is high for exactly one cycle after each halt; errFlag stays high until the next start clears it.
- R11: A start pulse during a run restarts at address 0 and discards any pending branch target or pending exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin (or restart) a run at address 0 |
| progLen | input | 15 | Number of instruction words loaded |
| instr | input | 32 | Instruction word read at fetchAddr |
| srcVal | input | 32 | Value of the register selected by srcSel |
| fetchAddr | output | 16 | Byte address of the instruction being handled |
| srcSel | output | 5 | Branch source register select |
| issue | output | 1 | Current instruction goes to the execute unit |
| done | output | 1 | One-cycle pulse when the run halts |
| errFlag | output | 1 | Illegal flow seen in the last run |

## Verification
The hardest situations to reach from the ports are the ones needing a delay slot that is itself special: an exit flag or a branch inside a slot, and a restart arriving while a delayed target is still pending. Directed programs place exactly those words right behind a taken branch, and the restart case pulses start in the delay-slot cycle. A backward loop is reached by letting the bench's stand-in execute unit rewrite the tested register, and forward-only random programs mix every flag combination while a bench model of the sequencing predicts the issued address list, error and cycle count.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int INSTR_W  = 32;
  localparam int OP_HI    = 31;
  localparam int OP_LO    = 29;
  localparam int EXIT_BIT = 28;
  localparam int ANNUL_BIT = 27;
  localparam int COND_BIT = 26;
  localparam int SRC_HI   = 25;
  localparam int SRC_LO   = 21;
  localparam logic [2:0] OP_BRANCH = 3'b111;

  typedef enum logic [2:0] {
    PC_HOLD,
    PC_ZERO,
    PC_SEQ,
    PC_JUMP,
    PC_PEND
  } pcSel_e;

  typedef enum logic [1:0] {
    SLOT_NONE,
    SLOT_BRANCH,
    SLOT_EXIT
  } slot_e;

  typedef struct packed {
    pcSel_e pcSel;
    logic   tgtLoad;
  } seqCtl_t;
endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int SRC_W  = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [DATA_W-1:0]    srcVal,
  input  logic [PC_W-2:0]      progLen,
  output logic [PC_W-1:0]      pc,
  output logic [SRC_W-1:0]     srcSel,
  output logic                 isBranch,
  output logic                 exitBit,
  output logic                 annulBit,
  output logic                 taken,
  output logic                 overrun
);
  localparam int LEN_W = PC_W - 1;

  logic [PC_W-1:0] pendTgt;
  logic [PC_W-1:0] offExt;
  logic [PC_W-1:0] brTarget;
  logic [PC_W-1:0] seqPc;
  logic [LEN_W-1:0] wordIdx;

  assign isBranch = (instr[OP_HI:OP_LO] == OP_BRANCH);
  assign exitBit  = instr[EXIT_BIT];
  assign annulBit = instr[ANNUL_BIT];
  assign srcSel   = SRC_W'(instr[SRC_HI:SRC_LO]);
  assign taken    = instr[COND_BIT] ? (|srcVal) : ~(|srcVal);

  assign offExt   = PC_W'($signed(instr[OFF_W-1:0]));
  assign brTarget = pc + (offExt << 2);
  assign seqPc    = pc + PC_W'(4);
  assign wordIdx  = LEN_W'(pc[PC_W-1:2]);
  assign overrun  = (wordIdx >= progLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      pendTgt <= '0;
    end else begin
      unique case (ctl.pcSel)
        PC_ZERO: pc <= '0;
        PC_SEQ:  pc <= seqPc;
        PC_JUMP: pc <= brTarget;
        PC_PEND: pc <= pendTgt;
        default: pc <= pc;
      endcase
      if (ctl.pcSel == PC_ZERO) begin
        pendTgt <= '0;
      end else if (ctl.tgtLoad) begin
        pendTgt <= brTarget;
      end
    end
  end
endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    isBranch,
  input  logic    exitBit,
  input  logic    annulBit,
  input  logic    taken,
  input  logic    overrun,
  output seqCtl_t ctl,
  output logic    issue,
  output logic    done,
  output logic    errFlag
);
  logic  running;
  slot_e slot;
  slot_e nextSlot;
  logic  haltNow;
  logic  errNow;

  always_comb begin
    ctl.pcSel   = PC_HOLD;
    ctl.tgtLoad = 1'b0;
    issue       = 1'b0;
    haltNow     = 1'b0;
    errNow      = 1'b0;
    nextSlot    = slot;
    if (start) begin
      ctl.pcSel = PC_ZERO;
      nextSlot  = SLOT_NONE;
    end else if (running) begin
      if (overrun) begin
        haltNow = 1'b1;
        errNow  = 1'b1;
      end else if (slot != SLOT_NONE) begin
        if (isBranch) begin
          haltNow = 1'b1;
          errNow  = 1'b1;
        end else begin
          issue     = 1'b1;
          ctl.pcSel = (slot == SLOT_BRANCH) ? PC_PEND : PC_SEQ;
          nextSlot  = SLOT_NONE;
          haltNow   = (slot == SLOT_EXIT);
        end
      end else if (isBranch) begin
        if (taken && annulBit) begin
          ctl.pcSel = PC_JUMP;
        end else if (taken) begin
          ctl.pcSel   = PC_SEQ;
          ctl.tgtLoad = 1'b1;
          nextSlot    = SLOT_BRANCH;
        end else begin
          ctl.pcSel = PC_SEQ;
          if (exitBit) nextSlot = SLOT_EXIT;
        end
      end else begin
        issue     = 1'b1;
        ctl.pcSel = PC_SEQ;
        if (exitBit) nextSlot = SLOT_EXIT;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      slot    <= SLOT_NONE;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      slot    <= SLOT_NONE;
      done    <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      done <= haltNow;
      if (haltNow) begin
        running <= 1'b0;
        slot    <= SLOT_NONE;
      end else begin
        slot <= nextSlot;
      end
      if (errNow) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import seq_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int SRC_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [PC_W-2:0]     progLen,
  input  logic [INSTR_W-1:0]  instr,
  input  logic [DATA_W-1:0]   srcVal,
  output logic [PC_W-1:0]     fetchAddr,
  output logic [SRC_W-1:0]    srcSel,
  output logic                issue,
  output logic                done,
  output logic                errFlag
);
  seqCtl_t ctl;
  logic isBranch;
  logic exitBit;
  logic annulBit;
  logic taken;
  logic overrun;

  seq_datapath #(
    .PC_W(PC_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .SRC_W(SRC_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .instr(instr), .srcVal(srcVal),
    .progLen(progLen), .pc(fetchAddr), .srcSel(srcSel), .isBranch(isBranch),
    .exitBit(exitBit), .annulBit(annulBit), .taken(taken), .overrun(overrun)
  );

  seq_control uCtl (
    .clk(clk), .rstN(rstN), .start(start), .isBranch(isBranch),
    .exitBit(exitBit), .annulBit(annulBit), .taken(taken), .overrun(overrun),
    .ctl(ctl), .issue(issue), .done(done), .errFlag(errFlag)
  );
endmodule

// File: rtl/macro_seq_checker.sv
module macro_seq_checker #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [PC_W-1:0] fetchAddr,
  input logic            issue,
  input logic            done,
  input logic            errFlag
);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_no_issue_at_error: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !$past(issue));

  a_r10_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> done);

  a_r6_quiet_after_halt: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !issue);

  a_r2_aligned_issue: assert property (@(posedge clk) disable iff (!rstN)
    issue |-> (fetchAddr[1:0] == 2'b00));

  a_r11_restart_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (fetchAddr == '0));
endmodule

bind macro_seq macro_seq_checker #(.PC_W(PC_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .fetchAddr(fetchAddr),
  .issue(issue), .done(done), .errFlag(errFlag)
);

// File: tb/sim_macro_seq.sv
module sim_macro_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [14:0] progLen = '0;
  logic [31:0] instr;
  logic [31:0] srcVal;
  logic [15:0] fetchAddr;
  logic [4:0]  srcSel;
  logic        issue;
  logic        done;
  logic        errFlag;

  logic [31:0] mem [0:15];
  logic [31:0] regs [0:31];
  logic [31:0] regsInit [0:31];
  logic        loadReq = 1'b0;

  int nChecks = 0;
  int nFails = 0;
  int expAddr [0:255];
  int expN, expSteps;
  bit expErr;
  int gotAddr [0:255];

  always #5 clk = ~clk;

  macro_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .progLen(progLen), .instr(instr),
    .srcVal(srcVal), .fetchAddr(fetchAddr), .srcSel(srcSel), .issue(issue),
    .done(done), .errFlag(errFlag)
  );

  assign instr  = (fetchAddr[15:6] == '0) ? mem[fetchAddr[5:2]] : 32'h0;
  assign srcVal = regs[srcSel];

  always @(posedge clk) begin
    if (loadReq) begin
      for (int i = 0; i < 32; i++) regs[i] <= regsInit[i];
    end else if (issue && instr[20]) begin
      regs[instr[25:21]] <= {16'h0, instr[15:0]};
    end
  end

  function automatic logic [31:0] br(bit ex, bit an, bit cnd, int src, int off);
    logic [15:0] o = 16'(off);
    return {3'b111, ex, an, cnd, 5'(src), 5'b0, o};
  endfunction

  function automatic logic [31:0] op(bit ex, bit wr, int src, int imm);
    return {3'b001, ex, 2'b00, 5'(src), wr, 4'b0, 16'(imm)};
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic modelRun(input int len);
    int r [0:31];
    int pc = 0;
    int dly = 0;
    int tgt = 0;
    logic [31:0] w;
    for (int i = 0; i < 32; i++) r[i] = regsInit[i];
    expN = 0; expSteps = 0; expErr = 0;
    for (int k = 0; k < 200; k++) begin
      expSteps++;
      if ((pc >> 2) >= len) begin expErr = 1; break; end
      w = mem[pc >> 2];
      if (dly != 0) begin
        if (w[31:29] == 3'b111) begin expErr = 1; break; end
        expAddr[expN++] = pc;
        if (w[20]) r[w[25:21]] = int'(w[15:0]);
        if (dly == 2) break;
        pc = (dly == 1) ? tgt : ((pc + 4) & 16'hFFFF);
        dly = 0;
      end else if (w[31:29] == 3'b111) begin
        bit tk = w[26] ? (r[w[25:21]] != 0) : (r[w[25:21]] == 0);
        int t = (pc + 4 * int'($signed(w[15:0]))) & 16'hFFFF;
        if (tk && w[27]) pc = t;
        else if (tk) begin tgt = t; dly = 1; pc = pc + 4; end
        else begin pc = pc + 4; if (w[28]) dly = 2; end
      end else begin
        expAddr[expN++] = pc;
        if (w[20]) r[w[25:21]] = int'(w[15:0]);
        pc = pc + 4;
        if (w[28]) dly = 2;
      end
    end
  endtask

  task automatic runProg(input int len, input int restartAt, input string req);
    int gotN = 0;
    int steps = 0;
    progLen = 15'(len);
    loadReq = 1'b1;
    @(negedge clk);
    loadReq = 1'b0;
    modelRun(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (restartAt > 0) begin
      repeat (restartAt) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (steps < 500) begin
      #1;
      if (done) break;
      if (issue) gotAddr[gotN++] = fetchAddr;
      steps++;
      @(negedge clk);
    end
    check(done == 1'b1, {req, " done seen"}, done, 1);
    check(gotN == expN, {req, " issue count"}, gotN, expN);
    for (int i = 0; i < gotN && i < expN; i++)
      check(gotAddr[i] == expAddr[i], {req, " issue address"}, gotAddr[i], expAddr[i]);
    check(errFlag == expErr, {req, " error flag"}, errFlag, expErr);
    check(steps == expSteps, {req, " cycles to halt"}, steps, expSteps);
    @(negedge clk);
    #1;
    check(done == 1'b0, "R10 done lasts one cycle", done, 0);
    check(errFlag == expErr, "R10 error held", errFlag, expErr);
  endtask

  task automatic clearProg();
    for (int i = 0; i < 16; i++) mem[i] = op(0, 0, 0, 0);
    for (int i = 0; i < 32; i++) regsInit[i] = 32'h0;
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    clearProg();
    for (int i = 0; i < 32; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    check(issue == 0 && done == 0 && errFlag == 0, "R1 quiet after reset", issue, 0);
    check(fetchAddr == 0, "R1 address after reset", fetchAddr, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check(issue == 0 && done == 0, "R1 idle before start", issue, 0);

    // R2 R9: straight line, runs off the end
    clearProg();
    runProg(3, 0, "R9 overrun");

    // R6: exit at word 1, one more then halt
    clearProg();
    mem[1] = op(1, 0, 0, 0);
    runProg(4, 0, "R6 exit");

    // R5: annulled taken branch skips the following word
    clearProg();
    mem[0] = br(0, 1, 0, 2, 3);
    mem[3] = op(1, 0, 0, 0);
    runProg(6, 0, "R5 annul");

    // R4: delay slot then target
    mem[0] = br(0, 0, 0, 2, 3);
    runProg(6, 0, "R4 delay slot");

    // R3: not taken (non-zero test on zero register) continues
    mem[0] = br(0, 0, 1, 2, 3);
    runProg(6, 0, "R3 not taken");

    // R11: restart while a delayed target is pending
    mem[0] = br(0, 0, 0, 2, 3);
    runProg(6, 1, "R11 restart");

    // R8: branch inside a delay slot
    clearProg();
    mem[0] = br(0, 0, 0, 2, 3);
    mem[1] = br(0, 1, 0, 2, 2);
    runProg(6, 0, "R8 branch in slot");

    // R7: exit flag in a branch delay slot is ignored
    clearProg();
    mem[0] = br(0, 0, 0, 2, 3);
    mem[1] = op(1, 0, 0, 0);
    mem[4] = op(1, 0, 0, 0);
    runProg(8, 0, "R7 exit in branch slot");

    // R7: exit in the exit delay slot is ignored
    clearProg();
    mem[1] = op(1, 0, 0, 0);
    mem[2] = op(1, 0, 0, 0);
    runProg(8, 0, "R7 exit in exit slot");

    // R6: exit flag on a taken annulled branch is ignored
    clearProg();
    mem[0] = br(1, 1, 0, 2, 2);
    mem[3] = op(1, 0, 0, 0);
    runProg(8, 0, "R6 exit on taken branch");

    // R4 backward: loop back once after the register is rewritten
    clearProg();
    regsInit[1] = 32'd5;
    mem[0] = br(0, 1, 0, 3, 2);
    mem[1] = op(0, 1, 1, 0);
    mem[2] = br(0, 1, 1, 1, -1);
    mem[3] = op(1, 0, 0, 0);
    runProg(8, 0, "R4 backward branch");

    // R2..R9 random forward-only programs
    for (int n = 0; n < 40; n++) begin
      int len = 2 + int'($urandom_range(14));
      for (int i = 0; i < 32; i++)
        regsInit[i] = ($urandom_range(1) == 0) ? 32'h0 : {16'h0, 16'($urandom)};
      for (int i = 0; i < 16; i++) begin
        if ($urandom_range(9) < 4)
          mem[i] = br($urandom_range(9) < 2, $urandom_range(1) == 1, $urandom_range(1) == 1,
                      int'($urandom_range(3)), 1 + int'($urandom_range(2)));
        else
          mem[i] = op($urandom_range(9) < 2, $urandom_range(3) == 0,
                      int'($urandom_range(3)), int'($urandom_range(1)));
      end
      runProg(len, 0, "R2 random program");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule